// File: doc/BRIEF.md
# Free Page-Table-Entry Prefetch Filter

When a page walk finishes, the leaf page-table entry arrives together with the other entries in the same cache line. Those neighbours cost nothing to read. This block decides which of them are worth keeping as prefetched translations. Each neighbour is tagged with its signed free distance, which is its slot in the line minus the slot of the walked entry. A table of saturating usefulness counters holds one counter per distance. A neighbour whose counter is at or above a programmable threshold is admitted into a prefetch queue. A neighbour below the threshold is parked in a small sampler instead. The sampler lets the block keep measuring distances that it is currently rejecting.

Translation misses are looked up by virtual page number in both the prefetch queue and the sampler. A hit in either one credits the counter of the distance stored with that entry. When a credit lands on a counter that is already full, every counter is halved, so that old behaviour fades.

The scan is driven by a two-state machine:
- `SCAN_IDLE`: waits for a walk. The transition *walk accepted* moves it to `SCAN_RUN`.
- `SCAN_RUN`: visits one line slot per cycle. The transition *last slot done* returns it to `SCAN_IDLE`.

Top module: `ptef_filter`

## Requirements
- R1: After reset, `busy`, `pq_ins_valid`, `pq_hit` and `smp_hit` are 0. All distance counters are 0, and both the prefetch queue and the sampler are empty.
- R2: A walk is accepted only in `SCAN_IDLE`. `busy` is then high for exactly LINE_PTES cycles. A walk presented while `busy` is high is ignored and produces no insertion.
- R3: Slots are visited in ascending order, and the walked slot itself is skipped. For walk page V at offset o, slot s yields the candidate page V-o+s with distance s-o. Distance 0 never appears at the output.
- R4: A candidate whose distance counter is greater than or equal to `threshold` is pushed into the prefetch queue. It is also shown on `pq_ins_valid`/`pq_ins_vpn`/`pq_ins_dist` one cycle after its scan cycle. A threshold of 0 therefore admits every neighbour.
- R5: A candidate below the threshold goes into the sampler and does not appear on the insertion outputs.
- R6: `pq_hit` and `smp_hit` are registered one cycle after `miss_valid`. Each one reports whether a valid entry in its store holds `miss_vpn`.
- R7: A miss that hits adds one to the counter of the hit entry's distance. If both stores hit, the prefetch-queue entry's distance is used.
- R8: A credit to a counter already at its maximum (all ones) halves every counter, rounding down, and the credited counter is not incremented.
- R9: The prefetch queue holds PQ_DEPTH entries. When it is full, a new entry replaces the oldest.
- R10: The sampler holds SMP_DEPTH entries. When it is full, a new entry replaces the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid | input | 1 | Walk completion event |
| walk_vpn | input | VPN_W | Virtual page of the walked entry |
| walk_off | input | log2(LINE_PTES) | Slot of the walked entry in its line |
| threshold | input | CNT_W | Admission threshold for counters |
| miss_valid | input | 1 | Translation miss lookup request |
| miss_vpn | input | VPN_W | Virtual page being looked up |
| busy | output | 1 | Scan in progress; walks are ignored |
| pq_ins_valid | output | 1 | A neighbour was admitted to the prefetch queue |
| pq_ins_vpn | output | VPN_W | Virtual page of the admitted neighbour |
| pq_ins_dist | output | log2(LINE_PTES)+1 | Signed free distance of the admitted neighbour |
| pq_hit | output | 1 | Previous miss hit the prefetch queue |
| smp_hit | output | 1 | Previous miss hit the sampler |

## Verification
Suppose a walk is sampled at edge E0. The neighbour in slot s is decided in the scan cycle ending at E(s+1) and shows on the insertion outputs right after that edge. `busy` falls after E(LINE_PTES). The bench therefore collects insertions at the falling edge over a ten-cycle window and rebuilds a slot mask from the page numbers.

Hit flags are due one cycle after the miss is sampled. The counter credit takes effect at that same edge, so the next walk's decisions already see it. The bench drives every input at the falling edge and reads each result at the following falling edge. Counter values are never read directly; they are inferred from which slots a later walk admits at chosen thresholds.

// File: rtl/ptef_pkg.sv
package ptef_pkg;

    // Scan controller states
    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_t;

endpackage

// File: rtl/ptef_store.sv
// Small FIFO-replaced store, looked up by key; returns the tag of the
// lowest-index matching valid entry.
module ptef_store #(
    parameter int DEPTH = 16,
    parameter int KEY_W = 20,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [TAG_W-1:0] lk_tag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld_q;
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [PTR_W-1:0] wp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            wp_q  <= '0;
        end else if (wr_en) begin
            vld_q[wp_q] <= 1'b1;
            wp_q        <= (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[wp_q] <= wr_key;
            tag_q[wp_q] <= wr_tag;
        end
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_tag = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (vld_q[i] && key_q[i] == lk_key) begin
                lk_hit = 1'b1;
                lk_tag = tag_q[i];
            end
        end
    end
endmodule

// File: rtl/ptef_dist_table.sv
// One saturating usefulness counter per free distance; halves all on overflow.
module ptef_dist_table #(
    parameter int NDIST = 14,
    parameter int CNT_W = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NDIST-1:0][CNT_W-1:0] cnt_w;
    logic                        halve;

    assign halve  = inc_en && (cnt_w[inc_idx] == CNT_MAX);
    assign rd_cnt = cnt_w[rd_idx];

    for (genvar g = 0; g < NDIST; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                c_q <= '0;
            else if (halve)
                c_q <= c_q >> 1;
            else if (inc_en && inc_idx == IDX_W'(g))
                c_q <= c_q + 1'b1;
        end
        assign cnt_w[g] = c_q;
    end
endmodule

// File: rtl/ptef_filter.sv
module ptef_filter
    import ptef_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int LINE_PTES = 8,
    parameter int CNT_W     = 10,
    parameter int PQ_DEPTH  = 16,
    parameter int SMP_DEPTH = 8,
    localparam int OFF_W    = $clog2(LINE_PTES),
    localparam int DIST_W   = OFF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     walk_valid,
    input  logic [VPN_W-1:0]         walk_vpn,
    input  logic [OFF_W-1:0]         walk_off,
    input  logic [CNT_W-1:0]         threshold,
    input  logic                     miss_valid,
    input  logic [VPN_W-1:0]         miss_vpn,
    output logic                     busy,
    output logic                     pq_ins_valid,
    output logic [VPN_W-1:0]         pq_ins_vpn,
    output logic signed [DIST_W-1:0] pq_ins_dist,
    output logic                     pq_hit,
    output logic                     smp_hit
);
    localparam int NDIST = 2 * (LINE_PTES - 1);
    localparam int IDX_W = $clog2(NDIST);

    scan_state_t state_q, state_d;
    logic [VPN_W-1:0] base_q;
    logic [OFF_W-1:0] off_q, slot_q;

    logic signed [DIST_W-1:0] cand_dist;
    logic [DIST_W:0]          idx_wide;
    logic [IDX_W-1:0]         cand_idx;
    logic [VPN_W-1:0]         cand_vpn;
    logic                     scan_act, accept;
    logic [CNT_W-1:0]         cand_cnt;
    logic                     pq_lk_hit, smp_lk_hit;
    logic [IDX_W-1:0]         pq_lk_tag, smp_lk_tag;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE: if (walk_valid) state_d = SCAN_RUN;
            SCAN_RUN:  if (slot_q == OFF_W'(LINE_PTES-1)) state_d = SCAN_IDLE;
        endcase
    end

    // walk capture and slot walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
            slot_q <= '0;
        end else if (state_q == SCAN_IDLE && walk_valid) begin
            base_q <= walk_vpn - VPN_W'(walk_off);
            off_q  <= walk_off;
            slot_q <= '0;
        end else if (state_q == SCAN_RUN) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // candidate for the current slot
    assign cand_dist = {1'b0, slot_q} - {1'b0, off_q};
    assign cand_vpn  = base_q + VPN_W'(slot_q);
    assign idx_wide  = cand_dist[DIST_W-1]
                     ? ({cand_dist[DIST_W-1], cand_dist} + (DIST_W+1)'(LINE_PTES-1))
                     : ({cand_dist[DIST_W-1], cand_dist} + (DIST_W+1)'(LINE_PTES-2));
    assign cand_idx  = idx_wide[IDX_W-1:0];
    assign scan_act  = (state_q == SCAN_RUN) && (slot_q != off_q);
    assign accept    = scan_act && (cand_cnt >= threshold);

    ptef_dist_table #(.NDIST(NDIST), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (miss_valid && (pq_lk_hit || smp_lk_hit)),
        .inc_idx (pq_lk_hit ? pq_lk_tag : smp_lk_tag),
        .rd_idx  (cand_idx),
        .rd_cnt  (cand_cnt)
    );

    ptef_store #(.DEPTH(PQ_DEPTH), .KEY_W(VPN_W), .TAG_W(IDX_W)) i_pq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_key (cand_vpn),
        .wr_tag (cand_idx),
        .lk_key (miss_vpn),
        .lk_hit (pq_lk_hit),
        .lk_tag (pq_lk_tag)
    );

    ptef_store #(.DEPTH(SMP_DEPTH), .KEY_W(VPN_W), .TAG_W(IDX_W)) i_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (scan_act && !accept),
        .wr_key (cand_vpn),
        .wr_tag (cand_idx),
        .lk_key (miss_vpn),
        .lk_hit (smp_lk_hit),
        .lk_tag (smp_lk_tag)
    );

    // outputs
    assign busy = (state_q == SCAN_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_ins_valid <= 1'b0;
            pq_ins_vpn   <= '0;
            pq_ins_dist  <= '0;
            pq_hit       <= 1'b0;
            smp_hit      <= 1'b0;
        end else begin
            pq_ins_valid <= accept;
            pq_ins_vpn   <= cand_vpn;
            pq_ins_dist  <= cand_dist;
            pq_hit       <= miss_valid && pq_lk_hit;
            smp_hit      <= miss_valid && smp_lk_hit;
        end
    end
endmodule

// File: rtl/ptef_filter_chk.sv
module ptef_filter_chk #(
    parameter int LINE_PTES = 8,
    parameter int DIST_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              walk_valid,
    input logic              miss_valid,
    input logic              busy,
    input logic              pq_ins_valid,
    input logic [DIST_W-1:0] pq_ins_dist,
    input logic              pq_hit,
    input logic              smp_hit
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R2
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_valid && !busy) |=> busy);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(LINE_PTES)));

    // R3
    no_zero_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pq_ins_valid |-> (pq_ins_dist != '0));

    // R4
    ins_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pq_ins_valid |-> $past(busy));

    // R6
    hit_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_hit || smp_hit) |-> $past(miss_valid));
endmodule

bind ptef_filter ptef_filter_chk #(.LINE_PTES(LINE_PTES), .DIST_W(DIST_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .walk_valid   (walk_valid),
    .miss_valid   (miss_valid),
    .busy         (busy),
    .pq_ins_valid (pq_ins_valid),
    .pq_ins_dist  (pq_ins_dist),
    .pq_hit       (pq_hit),
    .smp_hit      (smp_hit)
);

// File: tb/test_ptef_filter.sv
module test_ptef_filter;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              walk_valid = 1'b0;
    logic [19:0]       walk_vpn = '0;
    logic [2:0]        walk_off = '0;
    logic [9:0]        threshold = '0;
    logic              miss_valid = 1'b0;
    logic [19:0]       miss_vpn = '0;
    logic              busy;
    logic              pq_ins_valid;
    logic [19:0]       pq_ins_vpn;
    logic signed [3:0] pq_ins_dist;
    logic              pq_hit;
    logic              smp_hit;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ptef_filter i_ptef_filter (
        .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_vpn(walk_vpn),
        .walk_off(walk_off), .threshold(threshold), .miss_valid(miss_valid),
        .miss_vpn(miss_vpn), .busy(busy), .pq_ins_valid(pq_ins_valid),
        .pq_ins_vpn(pq_ins_vpn), .pq_ins_dist(pq_ins_dist), .pq_hit(pq_hit),
        .smp_hit(smp_hit)
    );

    // {op(0 walk,1 miss), vpn, off, thr, expected (walk: slot mask, miss: {pq,smp})}
    localparam logic [41:0] VEC [16] = '{
        {1'b0, 20'h00100, 3'd3, 10'd0, 8'hF7}, // R4 thr 0 admits all
        {1'b0, 20'h00205, 3'd5, 10'd1, 8'h00}, // R5 all to sampler
        {1'b1, 20'h00203, 3'd0, 10'd0, 8'h01}, // R6 sampler hit, -2 -> 1
        {1'b1, 20'h000FE, 3'd0, 10'd0, 8'h02}, // R6 queue hit, -2 -> 2
        {1'b1, 20'h00555, 3'd0, 10'd0, 8'h00}, // R6 no hit
        {1'b0, 20'h00302, 3'd2, 10'd2, 8'h01}, // R7 only -2 reaches 2
        {1'b1, 20'h00201, 3'd0, 10'd0, 8'h00}, // R10 evicted from sampler
        {1'b1, 20'h00207, 3'd0, 10'd0, 8'h01}, // R10 still in sampler, +2 -> 1
        {1'b1, 20'h00300, 3'd0, 10'd0, 8'h02}, // R6 -2 -> 3
        {1'b0, 20'h00400, 3'd0, 10'd1, 8'h04}, // R7 +2 admitted
        {1'b1, 20'h00402, 3'd0, 10'd0, 8'h02}, // R6 +2 -> 2
        {1'b0, 20'h00507, 3'd7, 10'd0, 8'h7F}, // R3 negative distances
        {1'b0, 20'h00600, 3'd0, 10'd0, 8'hFE}, // R9 fills past depth
        {1'b1, 20'h000FE, 3'd0, 10'd0, 8'h00}, // R9 oldest replaced
        {1'b1, 20'h00300, 3'd0, 10'd0, 8'h02}, // R9 newer kept, -2 -> 4
        {1'b1, 20'h00601, 3'd0, 10'd0, 8'h02}  // R6 +1 -> 1
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic collect(input logic [19:0] base, input logic [2:0] off,
                           output logic [7:0] got, output bit ok);
        got = '0;
        ok  = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (pq_ins_valid) begin
                int slot;
                slot = int'(pq_ins_vpn - base);
                if (slot < 0 || slot > 7) ok = 1'b0;
                else begin
                    got[slot] = 1'b1;
                    if (int'(pq_ins_dist) != slot - int'(off)) ok = 1'b0;
                end
            end
        end
    endtask

    task automatic do_walk(input logic [19:0] vpn, input logic [2:0] off,
                           input logic [9:0] thr, input logic [7:0] exp_m, input string req);
        logic [7:0] got;
        bit ok;
        @(negedge clk);
        walk_valid = 1'b1; walk_vpn = vpn; walk_off = off; threshold = thr;
        @(negedge clk);
        walk_valid = 1'b0;
        collect(vpn - 20'(off), off, got, ok);
        chk(got == exp_m, req, int'(got), int'(exp_m));
        chk(ok, {req, " R3 page/distance"}, int'(ok), 1);
    endtask

    task automatic do_miss(input logic [19:0] vpn, input logic [1:0] exp_h, input string req);
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn;
        @(negedge clk);
        miss_valid = 1'b0;
        chk({pq_hit, smp_hit} == exp_h, req, int'({pq_hit, smp_hit}), int'(exp_h));
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", int'(busy), 0);
        chk(!pq_ins_valid, "R1 ins_valid", int'(pq_ins_valid), 0);
        chk(!pq_hit, "R1 pq_hit", int'(pq_hit), 0);
        chk(!smp_hit, "R1 smp_hit", int'(smp_hit), 0);
        do_miss(20'h00100, 2'b00, "R1 stores empty");

        for (int v = 0; v < 16; v++) begin
            if (VEC[v][41])
                do_miss(VEC[v][40:21], VEC[v][1:0], $sformatf("R6 vector %0d", v));
            else
                do_walk(VEC[v][40:21], VEC[v][20:18], VEC[v][17:8], VEC[v][7:0],
                        $sformatf("R4 vector %0d", v));
        end

        // R2: second walk while busy is ignored
        @(negedge clk);
        walk_valid = 1'b1; walk_vpn = 20'h00700; walk_off = 3'd0; threshold = 10'd0;
        @(negedge clk);
        walk_vpn = 20'h00800;
        chk(busy, "R2 busy after walk", int'(busy), 1);
        @(negedge clk);
        walk_valid = 1'b0;
        collect(20'h00700, 3'd0, got, ok);
        chk(got == 8'hFE, "R2 only first walk", int'(got), 8'hFE);
        chk(ok, "R2 no stray insert", int'(ok), 1);
        chk(!busy, "R2 idle after scan", int'(busy), 0);

        // R8: drive the +3 counter to its maximum
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = 20'h00703;
        repeat (1023) @(negedge clk);
        miss_valid = 1'b0;
        do_walk(20'h00D02, 3'd2, 10'd4, 8'h21, "R8 before halving, -2 at 4");
        do_walk(20'h00900, 3'd0, 10'd1023, 8'h08, "R8 +3 at maximum");
        do_miss(20'h00703, 2'b10, "R8 credit at maximum");
        do_walk(20'h00A02, 3'd2, 10'd512, 8'h00, "R8 +3 halved to 511");
        do_walk(20'h00B02, 3'd2, 10'd3, 8'h20, "R8 -2 halved below 3");
        do_walk(20'h00C02, 3'd2, 10'd2, 8'h21, "R8 -2 halved to 2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule